// File: doc/BRIEF.md
# Planar Video Shift Serializer

This block turns four bytes fetched from the four planes of a planar frame buffer into a stream of pixels. A character-rate load strobe captures one byte per plane into four 8-bit shift lanes. Each following pixel-rate shift sends the most significant bit of every lane out together, so each clock yields a 4-bit pixel. Bit n of that pixel comes from lane n.

A 2-bit mode input chooses how plane bits are routed into the lanes at load time. The choices are straight planar, interleaved two-bits-per-pixel, and packed 256-colour nibbles. A separate wide input turns the block into a byte path that emits one whole plane byte per clock. When loads are skipped, the chain input links the four lanes into one 32-bit shifter, so a large monochrome or four-colour bitmap can be scrolled through the output. A shift-enable input freezes the lanes during blanking.

Top module: `planar_serializer`

## Requirements
- R1: While rst_n is low, and after it is released with no load, all lanes are zero and pix_o reads 0.
- R2: Mode 00, narrow path: lane n holds plane n's byte, and pix_o[n] emits plane n bits 7,6,...,0 on successive clocks after the load.
- R3: Mode 01, narrow path: pix_o[0] emits plane 0 bits 6,4,2,0, then plane 1 bits 6,4,2,0. pix_o[1] emits the odd bits 7,5,3,1 of plane 0 and then of plane 1. pix_o[2] and pix_o[3] do the same with planes 2 and 3.
- R4: Mode 1x (bit 0 ignored), narrow path: on clock 2p the pixel is the high nibble of plane p, and on clock 2p+1 it is the low nibble of plane p, for p = 0..3.
- R5: A load wins over a shift in the same cycle. The first pixel of the loaded data is on pix_o in the cycle after the load edge.
- R6: With load_i and shift_i both low, the lanes and pix_o hold their values.
- R7: On a narrow shift with chain_i high, lane n takes lane n+1's outgoing bit, and lane 3 takes 0. So pix_o[n] continues with the contents of lanes n+1, n+2 and so on. With chain_i low, every lane takes 0.
- R8: When wide_i is 1 and mode bit 1 is 0, the load stores the planes unrouted. pix_o shows plane 0, 1, 2 and 3 whole on four successive clocks, and 0 afterwards.
- R9: When wide_i is 1 and mode bit 1 is 1, the setting is illegal and pix_o reads 0.
- R10: On the narrow path, pix_o[7:4] are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Character-rate load strobe |
| shift_i | input | 1 | Shift enable (low during blanking) |
| chain_i | input | 1 | Link the lanes into one shifter on narrow shifts |
| wide_i | input | 1 | Select the byte-per-clock path |
| mode_i | input | 2 | Routing mode: 00 planar, 01 interleaved, 1x packed |
| plane_i | input | 32 | Plane bytes, plane n at bits 8n+7:8n |
| pix_o | output | 8 | Pixel: 4 bits on the narrow path, a byte on the wide path |

## Verification
Every routing setting is loaded with each of the 32 single-bit plane words. Each run traces exactly one lit source bit to the output bit and clock where it must appear, which separates the straight, interleaved and packed routings bit by bit and exposes any swapped index. All-zero, all-one and pseudo-random words check that neighbouring bits do not disturb one another. Each setting is run both chained and unchained for 36 clocks, which separates zero fill from lane-to-lane carry. Some runs pause the shift or load while shift is already high, to show hold and load priority.

// File: rtl/planar_ser_pkg.sv
package planar_ser_pkg;
  localparam int unsigned NPLANE_D = 4;
  localparam int unsigned PBITS_D  = 8;

  localparam logic [1:0] MODE_PLANAR = 2'b00;
  localparam logic [1:0] MODE_ILEAVE = 2'b01;
endpackage

// File: rtl/pser_route.sv
// Load-time routing of plane bytes into lane words.
module pser_route #(
  parameter int unsigned NPLANE = 4,
  parameter int unsigned W      = 8
) (
  input  logic [1:0]                     mode_i,
  input  logic                           wide_i,
  input  logic [NPLANE-1:0][W-1:0]       pl_i,
  output logic [NPLANE-1:0][W-1:0]       ld_o
);
  import planar_ser_pkg::*;
  localparam int unsigned HALF = W / 2;

  logic [NPLANE-1:0][W-1:0] ilv;
  logic [NPLANE-1:0][W-1:0] pck;

  // stream position j leaves at clock j, held at lane bit W-1-j
  for (genvar n = 0; n < NPLANE; n++) begin : g_lane
    for (genvar j = 0; j < W; j++) begin : g_pos
      localparam int unsigned IP = 2 * (n / 2) + j / HALF;
      localparam int unsigned IB = W - 2 - 2 * (j % HALF) + (n % 2);
      localparam int unsigned PP = j / 2;
      localparam int unsigned PB = ((j % 2) == 0) ? HALF + n : n;
      assign ilv[n][W-1-j] = pl_i[IP][IB];
      assign pck[n][W-1-j] = pl_i[PP][PB];
    end
  end

  always_comb begin
    if (wide_i || (mode_i == MODE_PLANAR)) begin
      ld_o = pl_i;
    end else if (mode_i == MODE_ILEAVE) begin
      ld_o = ilv;
    end else begin
      ld_o = pck;
    end
  end
endmodule

// File: rtl/pser_lane.sv
// One 8-bit video shift lane.
module pser_lane #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic         wide_i,
  input  logic [W-1:0] ld_i,
  input  logic         ser_i,
  input  logic [W-1:0] byte_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q_o;
    if (load_i) begin
      q_nxt = ld_i;
    end else if (shift_i) begin
      if (wide_i) q_nxt = byte_i;
      else        q_nxt = {q_o[W-2:0], ser_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_nxt;
  end

  p_load_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (q_o == $past(ld_i)));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !shift_i) |=> $stable(q_o));
  p_bitshift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && shift_i && !wide_i) |=> (q_o[W-1:1] == $past(q_o[W-2:0])));
  p_byteshift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && shift_i && wide_i) |=> (q_o == $past(byte_i)));
endmodule

// File: rtl/pser_out.sv
// Output formatting: narrow pixel or wide byte.
module pser_out #(
  parameter int unsigned NPLANE = 4,
  parameter int unsigned W      = 8
) (
  input  logic                     wide_i,
  input  logic                     mode_hi_i,
  input  logic [NPLANE-1:0][W-1:0] q_i,
  output logic [W-1:0]             pix_o
);
  logic [NPLANE-1:0] msb;

  for (genvar n = 0; n < NPLANE; n++) begin : g_msb
    assign msb[n] = q_i[n][W-1];
  end

  always_comb begin
    if (wide_i) pix_o = mode_hi_i ? '0 : q_i[0];
    else        pix_o = {{(W-NPLANE){1'b0}}, msb};
  end
endmodule

// File: rtl/planar_serializer.sv
module planar_serializer
  import planar_ser_pkg::*;
#(
  parameter int unsigned NPLANE = NPLANE_D,
  parameter int unsigned W      = PBITS_D
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic                  shift_i,
  input  logic                  chain_i,
  input  logic                  wide_i,
  input  logic [1:0]            mode_i,
  input  logic [NPLANE*W-1:0]   plane_i,
  output logic [W-1:0]          pix_o
);
  localparam int unsigned LAST = NPLANE - 1;

  logic [NPLANE-1:0][W-1:0] pl;
  logic [NPLANE-1:0][W-1:0] ld;
  logic [NPLANE-1:0][W-1:0] q;
  logic [NPLANE-1:0]        ser;
  logic [NPLANE-1:0][W-1:0] nbyte;

  assign pl = plane_i;

  pser_route #(.NPLANE(NPLANE), .W(W)) u_route (
    .mode_i (mode_i),
    .wide_i (wide_i),
    .pl_i   (pl),
    .ld_o   (ld)
  );

  for (genvar n = 0; n < NPLANE; n++) begin : g_lane
    if (n == LAST) begin : g_tail
      assign ser[n]   = 1'b0;
      assign nbyte[n] = '0;
    end else begin : g_link
      assign ser[n]   = chain_i & q[n+1][W-1];
      assign nbyte[n] = q[n+1];
    end
    pser_lane #(.W(W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_i),
      .shift_i (shift_i),
      .wide_i  (wide_i),
      .ld_i    (ld[n]),
      .ser_i   (ser[n]),
      .byte_i  (nbyte[n]),
      .q_o     (q[n])
    );
  end

  pser_out #(.NPLANE(NPLANE), .W(W)) u_out (
    .wide_i    (wide_i),
    .mode_hi_i (mode_i[1]),
    .q_i       (q),
    .pix_o     (pix_o)
  );

  p_tail_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && shift_i && !wide_i) |=> (q[LAST][0] == 1'b0));
  p_illegal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_i && mode_i[1]) |-> (pix_o == '0));
  p_narrow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_i |-> (pix_o[W-1:NPLANE] == '0));
endmodule

// File: tb/sim_planar_serializer.sv
module sim_planar_serializer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_i, shift_i, chain_i, wide_i;
  logic [1:0]  mode_i;
  logic [31:0] plane_i;
  logic [7:0]  pix_o;
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  planar_serializer u0 (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .shift_i(shift_i),
    .chain_i(chain_i), .wide_i(wide_i), .mode_i(mode_i),
    .plane_i(plane_i), .pix_o(pix_o)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic src(input logic [31:0] p, input int pl, input int b);
    return p[8*pl + b];
  endfunction

  // lane word expected after a load, from the routing rules
  function automatic logic [7:0] lane_word(input int n, input logic [1:0] m,
                                           input logic wd, input logic [31:0] p);
    logic [7:0] r;
    r = '0;
    for (int j = 0; j < 8; j++) begin
      if (wd || m == 2'b00)  r[7-j] = src(p, n, 7-j);
      else if (m[1])         r[7-j] = src(p, j/2, (j%2 == 0) ? 4+n : n);
      else                   r[7-j] = src(p, 2*(n/2) + j/4, 6 - 2*(j%4) + n%2);
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_pix(input int k, input logic [1:0] m, input logic wd,
                                         input logic ch, input logic [31:0] p);
    logic [7:0] r;
    logic [7:0] w;
    int lane;
    r = '0;
    if (wd) begin
      if (!m[1] && k < 4) r = p[8*k +: 8];
    end else begin
      for (int n = 0; n < 4; n++) begin
        lane = ch ? n + k/8 : ((k < 8) ? n : 4);
        if (lane < 4) begin
          w = lane_word(lane, m, wd, p);
          r[n] = w[7 - k%8];
        end
      end
    end
    return r;
  endfunction

  function automatic string tag(input int k, input logic [1:0] m, input logic wd, input logic ch);
    if (wd && m[1]) return "R9";
    if (wd)         return "R8";
    if (k == 0)     return "R5";
    if (k >= 8)     return "R7";
    if (m == 2'b00) return "R2";
    if (m == 2'b01) return "R3";
    return "R4";
  endfunction

  task automatic run(input logic [1:0] m, input logic wd, input logic ch,
                     input logic [31:0] p, input logic sh_at_load, input int pause_at);
    @(negedge clk);
    mode_i = m; wide_i = wd; chain_i = ch; plane_i = p;
    load_i = 1'b1; shift_i = sh_at_load;
    @(negedge clk);
    load_i = 1'b0;
    for (int k = 0; k < 36; k++) begin
      chk(tag(k, m, wd, ch), pix_o, exp_pix(k, m, wd, ch, p));
      if (!wd) chk("R10", {pix_o[7:4], 4'h0}, 8'h00);
      if (k == pause_at) begin
        shift_i = 1'b0;
        @(negedge clk);
        chk("R6", pix_o, exp_pix(k, m, wd, ch, p));
        @(negedge clk);
        chk("R6", pix_o, exp_pix(k, m, wd, ch, p));
      end
      shift_i = 1'b1;
      @(negedge clk);
    end
    shift_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired got=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] lcg;
    logic [31:0] pat;
    rst_n = 1'b0; load_i = 1'b0; shift_i = 1'b0; chain_i = 1'b0;
    wide_i = 1'b0; mode_i = 2'b00; plane_i = 32'hA5C3_7E19;
    repeat (3) @(negedge clk);
    chk("R1", pix_o, 8'h00);
    rst_n = 1'b1;
    shift_i = 1'b1;
    @(negedge clk);
    chk("R1", pix_o, 8'h00);
    shift_i = 1'b0;

    lcg = 32'h1234_5678;
    for (int m = 0; m < 4; m++) begin
      for (int wd = 0; wd < 2; wd++) begin
        for (int ch = 0; ch < 2; ch++) begin
          for (int i = 0; i < 36; i++) begin
            if (i < 32)       pat = 32'h1 << i;
            else if (i == 32) pat = 32'h0;
            else if (i == 33) pat = 32'hFFFF_FFFF;
            else begin
              lcg = lcg * 32'd1664525 + 32'd1013904223;
              pat = lcg;
            end
            run(m[1:0], wd[0], ch[0], pat, i[0], (i % 3 == 0) ? 3 : 99);
          end
        end
      end
    end

    // reset clears loaded data
    @(negedge clk);
    mode_i = 2'b00; wide_i = 1'b0; plane_i = 32'hFFFF_FFFF; load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    chk("R2", pix_o, 8'h0F);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", pix_o, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", pix_o, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule